// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Counter

This block is an 8-bit up-counter with two compare registers, three sticky event flags (compare A, compare B, overflow) and one control register. The control register picks the event that advances the counter: one of three prescaled clock enables from the system, a chosen edge of an external clock pin, or nothing. It also picks the event that returns the counter to zero, and it holds an enable for each flag's interrupt line. The external clock and the external reset pin are brought into the system clock domain by two flip-flops each, and their edges are found there.

Software reaches the five registers through a simple bus: a write strobe, a read strobe, an address and a data word. Read data is combinational from the address. A flag can only be cleared by first reading it as 1 and then writing 0 to its bit. When a flag-setting event and a clear land in the same cycle, the set wins.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the control, status, counter and both compare registers read 0 and all three interrupt lines are low.
- R2: Register map: address 0 control, 1 status, 2 counter, 3 compare A, 4 compare B. Control, counter and compare registers read back what was written. Any other address reads 0.
- R3: Control bit 7 enables the compare-B line, bit 6 the compare-A line, bit 5 the overflow line. Each line is high exactly while its flag and its enable are both 1.
- R4: Control bits 4:3 choose the clear source: 00 none, 01 compare A, 10 compare B, 11 rising edge of the external reset pin. In modes 01 and 10, a count event that arrives while the counter equals the selected compare value loads 0 instead of incrementing. In mode 11 a synchronized rising edge on the reset pin loads 0. In other modes that pin has no effect.
- R5: Control bits 2:0 choose the count event: 000 and 111 stop the counter; 001, 010 and 011 count on prescaler enable bits 0, 1 and 2 respectively. The other enable bits are ignored.
- R6: Codes 100, 101 and 110 count rising, falling or both edges of the external clock pin, after two-flop synchronization.
- R7: A compare flag (status bit 6 for A, bit 7 for B) is set when the counter becomes equal to that compare register.
- R8: The overflow flag (status bit 5) is set when a count event takes the counter from 0xFF to 0x00.
- R9: A flag is cleared by writing 0 to its status bit after a status read in which that bit was 1. Writing 0 without that read has no effect. A set event in the same cycle as a clear wins.
- R10: A counter write in the same cycle as a count event loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, arms flag clearing on a status read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| preEn | input | 3 | Prescaled clock enables, one per internal rate |
| extClk | input | 1 | External count clock, asynchronous |
| extRst | input | 1 | External counter-clear pin, asynchronous |
| irqCmpB | output | 1 | Compare-B interrupt request |
| irqCmpA | output | 1 | Compare-A interrupt request |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
The bench targets the same-cycle collisions. A status clear that meets a wrap must leave the overflow flag set; a design that lets the clear win loses the event. A counter write that meets a count event must load the written value; a design that lets the count win reads back one higher. It also writes 0 to a status bit that has not been read as 1, which a design that skips the arm step would wrongly clear. The bench checks that clear-on-match returns to 0 only on the count event after the match, not on the match itself, and that the external reset pin does nothing outside mode 11. Edge-select codes are checked by counting pin pulses, which shows a design that watches the wrong edge or drops a phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd4;

  localparam logic [1:0] CLR_NONE = 2'b00;
  localparam logic [1:0] CLR_CMPA = 2'b01;
  localparam logic [1:0] CLR_CMPB = 2'b10;
  localparam logic [1:0] CLR_PIN  = 2'b11;

  localparam logic [2:0] CK_STOP = 3'b000;
  localparam logic [2:0] CK_RISE = 3'b100;
  localparam logic [2:0] CK_FALL = 3'b101;
  localparam logic [2:0] CK_BOTH = 3'b110;
  localparam logic [2:0] CK_RSVD = 3'b111;

  typedef struct packed {
    logic cntEvt;
    logic extClr;
    logic wrCnt;
    logic wrCmpA;
    logic wrCmpB;
    logic wrStat;
    logic rdStat;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q,
  output logic qPrev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], d};
  end

  assign q     = chain[STAGES-1];
  assign qPrev = chain[STAGES];
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NPRE   = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DW-1:0]     busWdata,
  input  logic [NPRE-1:0]   preEn,
  input  logic              extClk,
  input  logic              extRst,
  output logic [7:0]        ctrlReg,
  output tmrStrobe_t        stb
);
  logic ckNow, ckOld, rsNow, rsOld;
  logic ckRise, ckFall, rsRise;
  logic [2:0] ckSel;
  logic [1:0] clrMode;
  logic evt;

  tmr_sync #(.STAGES(STAGES)) uClkSync (
    .clk(clk), .rstN(rstN), .d(extClk), .q(ckNow), .qPrev(ckOld));
  tmr_sync #(.STAGES(STAGES)) uRstSync (
    .clk(clk), .rstN(rstN), .d(extRst), .q(rsNow), .qPrev(rsOld));

  assign ckRise  = ckNow & ~ckOld;
  assign ckFall  = ~ckNow & ckOld;
  assign rsRise  = rsNow & ~rsOld;
  assign ckSel   = ctrlReg[2:0];
  assign clrMode = ctrlReg[4:3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ctrlReg <= '0;
    else if (busWr && busAddr == A_CTRL) ctrlReg <= busWdata[7:0];
  end

  always_comb begin
    evt = 1'b0;
    case (ckSel)
      CK_RISE: evt = ckRise;
      CK_FALL: evt = ckFall;
      CK_BOTH: evt = ckRise | ckFall;
      default: begin
        for (int i = 0; i < NPRE; i++)
          if (ckSel == 3'(i + 1)) evt = preEn[i];
      end
    endcase
  end

  always_comb begin
    stb.cntEvt = evt;
    stb.extClr = (clrMode == CLR_PIN) && rsRise;
    stb.wrCnt  = busWr && (busAddr == A_CNT);
    stb.wrCmpA = busWr && (busAddr == A_CMPA);
    stb.wrCmpB = busWr && (busAddr == A_CMPB);
    stb.wrStat = busWr && (busAddr == A_STAT);
    stb.rdStat = busRd && (busAddr == A_STAT);
  end

  // R5
  stopped_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntEvt |-> (ckSel != CK_STOP && ckSel != CK_RSVD));

  // R6
  edge_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ckSel == CK_RISE && stb.cntEvt) |-> (ckNow && !ckOld));
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        stb,
  input  logic [DW-1:0]     wdata,
  input  logic [7:0]        ctrlReg,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DW-1:0]     rdata,
  output logic [2:0]        flags
);
  localparam int NFLAG = 3;
  localparam int FLAG_LSB = 5;
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic [DW-1:0] cnt, cmpA, cmpB, cntNext;
  logic matchA, matchB, matchADly, matchBDly;
  logic clrOnEvt, wrapSet;
  logic [1:0] clrMode;
  logic [NFLAG-1:0] armed, setEv, clrReq, flagNext;
  logic [7:0] statRd;

  assign clrMode = ctrlReg[4:3];
  assign matchA  = (cnt == cmpA);
  assign matchB  = (cnt == cmpB);
  assign clrOnEvt = (clrMode == CLR_CMPA && matchA) || (clrMode == CLR_CMPB && matchB);
  assign wrapSet = stb.cntEvt && !stb.wrCnt && !stb.extClr && !clrOnEvt && (cnt == CNT_MAX);

  always_comb begin
    if (stb.wrCnt)       cntNext = wdata;
    else if (stb.extClr) cntNext = '0;
    else if (stb.cntEvt) cntNext = clrOnEvt ? '0 : cnt + DW'(1);
    else                 cntNext = cnt;
  end

  // flag order {B, A, overflow}, matching status bits 7..5
  assign setEv = {matchB & ~matchBDly, matchA & ~matchADly, wrapSet};

  for (genvar g = 0; g < NFLAG; g++) begin : gFlag
    assign clrReq[g]   = stb.wrStat & armed[g] & ~wdata[FLAG_LSB+g];
    assign flagNext[g] = setEv[g] | (flags[g] & ~clrReq[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      cmpA      <= '0;
      cmpB      <= '0;
      matchADly <= 1'b1;
      matchBDly <= 1'b1;
      flags     <= '0;
      armed     <= '0;
    end else begin
      cnt       <= cntNext;
      matchADly <= matchA;
      matchBDly <= matchB;
      flags     <= flagNext;
      if (stb.wrCmpA) cmpA <= wdata;
      if (stb.wrCmpB) cmpB <= wdata;
      if (stb.wrStat)      armed <= '0;
      else if (stb.rdStat) armed <= armed | flags;
    end
  end

  assign statRd = {flags, 5'b0};

  always_comb begin
    case (busAddr)
      A_CTRL:  rdata = DW'(ctrlReg);
      A_STAT:  rdata = DW'(statRd);
      A_CNT:   rdata = cnt;
      A_CMPA:  rdata = cmpA;
      A_CMPB:  rdata = cmpB;
      default: rdata = '0;
    endcase
  end

  // R10
  cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCnt |=> cnt == $past(wdata));

  // R5
  plain_increment_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntEvt && !stb.wrCnt && !stb.extClr && clrMode == CLR_NONE)
      |=> cnt == $past(cnt) + DW'(1));

  // R4
  pin_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.extClr && !stb.wrCnt) |=> cnt == '0);

  // R8
  ovf_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> $past(cnt) == CNT_MAX);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags[1] && !stb.wrStat) |=> flags[1]);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NPRE   = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  input  logic [NPRE-1:0]   preEn,
  input  logic              extClk,
  input  logic              extRst,
  output logic              irqCmpB,
  output logic              irqCmpA,
  output logic              irqOvf
);
  logic [7:0] ctrlReg;
  tmrStrobe_t stb;
  logic [2:0] flags;

  tmr_ctrl #(.DW(DW), .NPRE(NPRE), .STAGES(STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .preEn(preEn), .extClk(extClk), .extRst(extRst),
    .ctrlReg(ctrlReg), .stb(stb));

  tmr_dpath #(.DW(DW)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .ctrlReg(ctrlReg),
    .busAddr(busAddr), .rdata(busRdata), .flags(flags));

  assign irqCmpB = flags[2] & ctrlReg[7];
  assign irqCmpA = flags[1] & ctrlReg[6];
  assign irqOvf  = flags[0] & ctrlReg[5];

  // R3
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOvf) |-> (flags[0] || $past(flags[0])));
endmodule

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [2:0] preEn = '0;
  logic       extClk = 1'b0;
  logic       extRst = 1'b0;
  logic       irqCmpB, irqCmpA, irqOvf;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  dual_cmp_timer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .preEn(preEn), .extClk(extClk),
    .extRst(extRst), .irqCmpB(irqCmpB), .irqCmpA(irqCmpA), .irqOvf(irqOvf));

  // entry: {write address, write data, expected readback}
  localparam logic [18:0] VEC [0:8] = '{
    {3'd0, 8'hE0, 8'hE0},
    {3'd0, 8'h18, 8'h18},
    {3'd0, 8'h07, 8'h07},
    {3'd0, 8'h00, 8'h00},
    {3'd3, 8'h5A, 8'h5A},
    {3'd4, 8'hA5, 8'hA5},
    {3'd2, 8'h3C, 8'h3C},
    {3'd2, 8'h00, 8'h00},
    {3'd5, 8'h77, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic tick(input logic [2:0] mask, input int n);
    @(negedge clk);
    preEn = mask;
    repeat (n) @(negedge clk);
    preEn = '0;
  endtask

  task automatic wrTick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1; preEn = 3'b001;
    @(negedge clk);
    busWr = 1'b0; preEn = '0;
  endtask

  task automatic pinPulses(input int n, input bit onRst);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (onRst) extRst = 1'b1; else extClk = 1'b1;
      repeat (4) @(negedge clk);
      if (onRst) extRst = 1'b0; else extClk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got hang expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv); check("R1 register reset", rv, 8'h00);
    end
    check("R1 irq reset", {5'b0, irqCmpB, irqCmpA, irqOvf}, 8'h00);

    // R2 register readback table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], rv);
      check("R2 readback", rv, VEC[i][7:0]);
    end

    // R5 stopped codes
    tick(3'b111, 4); rd(3'd2, rv); check("R5 code 000 stopped", rv, 8'h00);
    wr(3'd0, 8'h07); tick(3'b111, 4); rd(3'd2, rv); check("R5 code 111 stopped", rv, 8'h00);
    // R5 prescaler selection
    wr(3'd0, 8'h01); tick(3'b001, 4); rd(3'd2, rv); check("R5 code 001", rv, 8'h04);
    wr(3'd0, 8'h02); tick(3'b001, 3); rd(3'd2, rv); check("R5 code 010 ignores bit0", rv, 8'h04);
    tick(3'b010, 3); rd(3'd2, rv); check("R5 code 010", rv, 8'h07);
    wr(3'd0, 8'h03); tick(3'b100, 2); rd(3'd2, rv); check("R5 code 011", rv, 8'h09);

    // R7 / R4 clear on compare A
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h05); wr(3'd0, 8'h09);
    tick(3'b001, 5); rd(3'd2, rv); check("R4 holds match value", rv, 8'h05);
    rd(3'd1, rv); check("R7 compare A flag", rv, 8'h40);
    tick(3'b001, 1); rd(3'd2, rv); check("R4 clear on A", rv, 8'h00);
    check("R3 irqCmpA gated off", {7'b0, irqCmpA}, 8'h00);
    wr(3'd0, 8'h49); #1 check("R3 irqCmpA enabled", {7'b0, irqCmpA}, 8'h01);

    // R9 clear protocol
    wr(3'd1, 8'h00); rd(3'd1, rv); check("R9 armed clear", rv, 8'h00);
    wr(3'd2, 8'h04); tick(3'b001, 1); wr(3'd1, 8'h00);
    rd(3'd1, rv); check("R9 unarmed write ignored", rv, 8'h40);
    wr(3'd1, 8'h00); #1 check("R3 irqCmpA after clear", {7'b0, irqCmpA}, 8'h00);
    rd(3'd1, rv); check("R9 cleared", rv, 8'h00);

    // R8 overflow
    wr(3'd0, 8'h01); wr(3'd2, 8'hFE); tick(3'b001, 2);
    rd(3'd2, rv); check("R8 wrap value", rv, 8'h00);
    rd(3'd1, rv); check("R8 overflow flag", rv, 8'h20);
    check("R3 irqOvf gated off", {7'b0, irqOvf}, 8'h00);
    wr(3'd0, 8'h21); #1 check("R3 irqOvf enabled", {7'b0, irqOvf}, 8'h01);
    // R9 set beats clear
    wr(3'd2, 8'hFF); wrTick(3'd1, 8'h00);
    rd(3'd1, rv); check("R9 set beats clear", rv, 8'h20);
    wr(3'd1, 8'h00); rd(3'd1, rv); check("R9 overflow cleared", rv, 8'h00);
    wr(3'd0, 8'h01);

    // R10 counter write beats count
    wrTick(3'd2, 8'h20); rd(3'd2, rv); check("R10 write wins", rv, 8'h20);

    // R4 clear on compare B, and no clear in mode 00
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'h03); wr(3'd0, 8'h11);
    tick(3'b001, 3); tick(3'b001, 1); rd(3'd2, rv); check("R4 clear on B", rv, 8'h00);
    rd(3'd1, rv); check("R7 compare B flag", rv, 8'h80);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01); wr(3'd2, 8'h02); tick(3'b001, 2);
    rd(3'd2, rv); check("R4 mode 00 no clear", rv, 8'h04);
    rd(3'd1, rv); wr(3'd1, 8'h00);

    // R6 external clock edges
    wr(3'd0, 8'h04); wr(3'd2, 8'h00); pinPulses(3, 1'b0);
    rd(3'd2, rv); check("R6 rising edges", rv, 8'h03);
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); pinPulses(3, 1'b0);
    rd(3'd2, rv); check("R6 falling edges", rv, 8'h03);
    wr(3'd0, 8'h06); wr(3'd2, 8'h00); pinPulses(3, 1'b0);
    rd(3'd2, rv); check("R6 both edges", rv, 8'h06);

    // R4 external reset pin
    wr(3'd0, 8'h00); wr(3'd2, 8'h40); pinPulses(1, 1'b1);
    rd(3'd2, rv); check("R4 pin ignored in mode 00", rv, 8'h40);
    wr(3'd0, 8'h18); pinPulses(1, 1'b1);
    rd(3'd2, rv); check("R4 pin clear in mode 11", rv, 8'h00);

    done = 1'b1;
    finishRun();
  end
endmodule